// File: doc/BRIEF.md
# Storage Task-File Register Front End

This block sits between a memory-mapped bus and a storage device core. It owns the byte-wide shadow registers of an ATA-style task file: feature, sector count, three address bytes and device/head. It forwards command bytes, device-control bytes and 16-bit data-port transfers to the core as one-cycle strobes. It returns status, error and shadow values on reads. Several addresses mean one thing when read and another when written. Writes to the shadow registers and the command byte are refused while the core reports itself busy or mid-transfer.

A level interrupt is raised by a completion pulse from the core. Reading the primary status address clears it, and so does an accepted command write. Reading the secondary status address returns the same byte and leaves the interrupt alone. Word addresses above the task file reach a plain scratch array.

The access controller is a three-state machine. In ST_IDLE it waits for a select. A select with the write flag set moves it to ST_WR, and a select without it moves it to ST_RD. The request is latched on that move. ST_WR returns to ST_IDLE after one cycle, and so does ST_RD. The acknowledge, the strobes and the read data all appear during the ST_WR or ST_RD cycle, and register updates take effect at the edge that ends it.

Top module: `tf_frontend`

## Requirements
- R1: After a synchronous active-low reset, all six shadow registers, the scratch words and the interrupt are zero, and the acknowledge and all strobes are low.
- R2: A select sampled in ST_IDLE produces a bus acknowledge in the next cycle, lasting exactly one cycle. A select held high is taken again only after the state machine has gone back to ST_IDLE.
- R3: Word addresses 1 (feature), 2 (count), 3, 4 and 5 (address bytes, low to high) and 6 (device/head) update their shadow register only if status bit 7 (busy) and bit 3 (data request) are both clear in the action cycle; otherwise the write is dropped. Reading addresses 2 to 6 returns the shadow value, zero-extended.
- R4: A shadow register write stores only bits 7:0 of the bus word.
- R5: A read of word address 1 returns the core's error byte, not the stored feature value.
- R6: An accepted write to word address 7 pulses the command strobe for one cycle with bits 7:0 as the command code, and clears the interrupt. A refused write to address 7 gives no strobe and leaves the interrupt as it was.
- R7: A read of word address 7 returns the core's status byte and clears the interrupt.
- R8: A read of word address 8 returns the status byte and leaves the interrupt unchanged. A write to address 8 pulses the device-control strobe with bits 7:0, whatever the busy state.
- R9: A write to word address 0 pulses the data-write strobe with bits 15:0. A read of address 0 pulses the data-read strobe and returns the core's 16-bit data, zero-extended. Neither is gated by busy.
- R10: At most one of the command, device-control, data-write and data-read strobes is high in any cycle, and only while the acknowledge is high.
- R11: A completion pulse sets the interrupt at the next edge. When a set and a clear fall on the same edge, the set wins.
- R12: Word addresses 9 and above store and return a full bus word in a scratch array, ungated by busy.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| bus_sel | input | 1 | Access request |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Word address |
| bus_wdata | input | DATA_W | Write data |
| bus_ack | output | 1 | Access completes this cycle |
| bus_rdata | output | DATA_W | Read data, valid with acknowledge on reads |
| dev_status | input | 8 | Core status byte |
| dev_error | input | 8 | Core error byte |
| dev_done | input | 1 | Core completion pulse |
| dev_pio_rdata | input | PIO_W | Core data-port read word |
| cmd_valid | output | 1 | Command strobe |
| cmd_code | output | 8 | Command byte |
| ctl_valid | output | 1 | Device-control strobe |
| ctl_data | output | 8 | Device-control byte |
| pio_wr | output | 1 | Data-port write strobe |
| pio_rd | output | 1 | Data-port read strobe |
| pio_wdata | output | PIO_W | Data-port write word |
| tf_feature | output | 8 | Feature shadow |
| tf_count | output | 8 | Sector count shadow |
| tf_lba0 | output | 8 | Address byte 0 |
| tf_lba1 | output | 8 | Address byte 1 |
| tf_lba2 | output | 8 | Address byte 2 |
| tf_device | output | 8 | Device/head shadow |
| irq | output | 1 | Interrupt level |

## Verification
The acknowledge, the four strobes, the command and control bytes and the read data are due in the cycle right after the select is sampled. Shadow, scratch and interrupt changes made by an access are due one cycle later, at the edge that ends ST_WR or ST_RD. An interrupt set by a completion pulse is due after the edge that samples that pulse. A behavioural model in the bench advances on each rising edge with the same stimulus, and every output is compared against it a quarter period later. Directed checks wait for the falling edge after the action cycle before they read any register value.

// File: rtl/tf_pkg.sv
package tf_pkg;
    typedef enum logic [1:0] {
        ST_IDLE,
        ST_WR,
        ST_RD
    } tf_state_e;

    // Word addresses whose meaning the device core depends on
    localparam int TF_DATA     = 0;
    localparam int TF_FEAT     = 1;
    localparam int TF_COUNT    = 2;
    localparam int TF_LBA0     = 3;
    localparam int TF_LBA1     = 4;
    localparam int TF_LBA2     = 5;
    localparam int TF_DEV      = 6;
    localparam int TF_CMD      = 7;
    localparam int TF_ALT      = 8;
    localparam int TF_SCR_BASE = 9;

    localparam int SHADOW_N = 6;
    localparam int BSY_BIT  = 7;
    localparam int DRQ_BIT  = 3;

    typedef logic [SHADOW_N-1:0][7:0] shadow_t;
endpackage

// File: rtl/tf_fsm.sv
module tf_fsm
    import tf_pkg::*;
#(
    parameter int ADDR_W = 4,
    parameter int DATA_W = 32
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                bus_sel,
    input  logic                bus_wr,
    input  logic [ADDR_W-1:0]   bus_addr,
    input  logic [DATA_W-1:0]   bus_wdata,
    input  logic                wr_allow,
    output logic                ack,
    output logic                rd_phase,
    output logic [ADDR_W-1:0]   req_addr,
    output logic [DATA_W-1:0]   req_wdata,
    output logic                cmd_valid,
    output logic                ctl_valid,
    output logic                pio_wr,
    output logic                pio_rd,
    output logic [SHADOW_N-1:0] shadow_we,
    output logic                scr_we,
    output logic                irq_clr
);
    tf_state_e state_q, state_d;

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (bus_sel) state_d = bus_wr ? ST_WR : ST_RD;
            ST_WR:   state_d = ST_IDLE;
            ST_RD:   state_d = ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            req_addr  <= '0;
            req_wdata <= '0;
        end else if (state_q == ST_IDLE && bus_sel) begin
            req_addr  <= bus_addr;
            req_wdata <= bus_wdata;
        end
    end

    always_comb begin
        ack       = 1'b0;
        rd_phase  = 1'b0;
        cmd_valid = 1'b0;
        ctl_valid = 1'b0;
        pio_wr    = 1'b0;
        pio_rd    = 1'b0;
        shadow_we = '0;
        scr_we    = 1'b0;
        irq_clr   = 1'b0;
        unique case (state_q)
            ST_IDLE: ;
            ST_WR: begin
                ack = 1'b1;
                for (int i = 0; i < SHADOW_N; i++)
                    shadow_we[i] = wr_allow && (req_addr == ADDR_W'(TF_FEAT + i));
                cmd_valid = wr_allow && (req_addr == ADDR_W'(TF_CMD));
                irq_clr   = wr_allow && (req_addr == ADDR_W'(TF_CMD));
                ctl_valid = (req_addr == ADDR_W'(TF_ALT));
                pio_wr    = (req_addr == ADDR_W'(TF_DATA));
                scr_we    = (req_addr >= ADDR_W'(TF_SCR_BASE));
            end
            ST_RD: begin
                ack      = 1'b1;
                rd_phase = 1'b1;
                pio_rd   = (req_addr == ADDR_W'(TF_DATA));
                irq_clr  = (req_addr == ADDR_W'(TF_CMD));
            end
            default: ;
        endcase
    end

    AST_ACK_SINGLE: assert property (@(posedge clk) disable iff (!rst_n) ack |=> !ack); // R2
    AST_SEL_TAKEN: assert property (@(posedge clk) disable iff (!rst_n) (state_q == ST_IDLE && bus_sel) |=> ack); // R2
endmodule

// File: rtl/tf_regs.sv
module tf_regs
    import tf_pkg::*;
#(
    parameter int NUM_WORDS = 16,
    parameter int ADDR_W    = 4,
    parameter int DATA_W    = 32,
    parameter int PIO_W     = 16
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [ADDR_W-1:0]   req_addr,
    input  logic [DATA_W-1:0]   req_wdata,
    input  logic [SHADOW_N-1:0] shadow_we,
    input  logic                scr_we,
    input  logic [7:0]          dev_status,
    input  logic [7:0]          dev_error,
    input  logic [PIO_W-1:0]    dev_pio_rdata,
    output shadow_t             shadow_q,
    output logic [DATA_W-1:0]   rd_data
);
    localparam int SCR_N  = NUM_WORDS - TF_SCR_BASE;
    localparam int SCR_W  = (SCR_N > 1) ? $clog2(SCR_N) : 1;
    localparam int SH_W   = $clog2(SHADOW_N);

    logic [SCR_N-1:0][DATA_W-1:0] scr_q;
    logic [SCR_W-1:0] scr_idx;
    logic [SH_W-1:0]  sh_idx;

    assign scr_idx = SCR_W'(req_addr - ADDR_W'(TF_SCR_BASE));
    assign sh_idx  = SH_W'(req_addr - ADDR_W'(TF_FEAT));

    generate
        for (genvar g = 0; g < SHADOW_N; g++) begin : g_shadow
            always_ff @(posedge clk) begin
                if (!rst_n)          shadow_q[g] <= '0;
                else if (shadow_we[g]) shadow_q[g] <= req_wdata[7:0];
            end
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            scr_q <= '0;
        end else if (scr_we) begin
            for (int s = 0; s < SCR_N; s++)
                if (int'(scr_idx) == s) scr_q[s] <= req_wdata;
        end
    end

    always_comb begin
        rd_data = '0;
        case (int'(req_addr))
            TF_DATA: rd_data = DATA_W'(dev_pio_rdata);
            TF_FEAT: rd_data = DATA_W'(dev_error);
            TF_COUNT, TF_LBA0, TF_LBA1, TF_LBA2, TF_DEV:
                rd_data = DATA_W'(shadow_q[sh_idx]);
            TF_CMD, TF_ALT: rd_data = DATA_W'(dev_status);
            default: if (int'(scr_idx) < SCR_N) rd_data = scr_q[scr_idx];
        endcase
    end

    AST_SHADOW_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n) $onehot0(shadow_we)); // R3
endmodule

// File: rtl/tf_irq.sv
module tf_irq (
    input  logic clk,
    input  logic rst_n,
    input  logic set,
    input  logic clr,
    output logic irq
);
    always_ff @(posedge clk) begin
        if (!rst_n)   irq <= 1'b0;
        else if (set) irq <= 1'b1;
        else if (clr) irq <= 1'b0;
    end

    AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n) set |=> irq); // R11
    AST_RISE_CAUSE: assert property (@(posedge clk) disable iff (!rst_n) $rose(irq) |-> $past(set)); // R11
endmodule

// File: rtl/tf_frontend.sv
module tf_frontend
    import tf_pkg::*;
#(
    parameter  int NUM_WORDS = 16,
    parameter  int DATA_W    = 32,
    parameter  int PIO_W     = 16,
    localparam int ADDR_W    = $clog2(NUM_WORDS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic              bus_ack,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic [7:0]        dev_status,
    input  logic [7:0]        dev_error,
    input  logic              dev_done,
    input  logic [PIO_W-1:0]  dev_pio_rdata,
    output logic              cmd_valid,
    output logic [7:0]        cmd_code,
    output logic              ctl_valid,
    output logic [7:0]        ctl_data,
    output logic              pio_wr,
    output logic              pio_rd,
    output logic [PIO_W-1:0]  pio_wdata,
    output logic [7:0]        tf_feature,
    output logic [7:0]        tf_count,
    output logic [7:0]        tf_lba0,
    output logic [7:0]        tf_lba1,
    output logic [7:0]        tf_lba2,
    output logic [7:0]        tf_device,
    output logic              irq
);
    logic                wr_allow;
    logic                rd_phase;
    logic [ADDR_W-1:0]   req_addr;
    logic [DATA_W-1:0]   req_wdata;
    logic [SHADOW_N-1:0] shadow_we;
    logic                scr_we;
    logic                irq_clr;
    logic [DATA_W-1:0]   rd_data;
    shadow_t             shadow_q;

    assign wr_allow = !dev_status[BSY_BIT] && !dev_status[DRQ_BIT];

    tf_fsm #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_fsm (
        .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .wr_allow(wr_allow),
        .ack(bus_ack), .rd_phase(rd_phase), .req_addr(req_addr),
        .req_wdata(req_wdata), .cmd_valid(cmd_valid), .ctl_valid(ctl_valid),
        .pio_wr(pio_wr), .pio_rd(pio_rd), .shadow_we(shadow_we),
        .scr_we(scr_we), .irq_clr(irq_clr)
    );

    tf_regs #(.NUM_WORDS(NUM_WORDS), .ADDR_W(ADDR_W), .DATA_W(DATA_W), .PIO_W(PIO_W)) u_regs (
        .clk(clk), .rst_n(rst_n), .req_addr(req_addr), .req_wdata(req_wdata),
        .shadow_we(shadow_we), .scr_we(scr_we), .dev_status(dev_status),
        .dev_error(dev_error), .dev_pio_rdata(dev_pio_rdata),
        .shadow_q(shadow_q), .rd_data(rd_data)
    );

    tf_irq u_irq (
        .clk(clk), .rst_n(rst_n), .set(dev_done), .clr(irq_clr), .irq(irq)
    );

    assign bus_rdata  = rd_phase ? rd_data : '0;
    assign cmd_code   = req_wdata[7:0];
    assign ctl_data   = req_wdata[7:0];
    assign pio_wdata  = req_wdata[PIO_W-1:0];
    assign tf_feature = shadow_q[TF_FEAT  - TF_FEAT];
    assign tf_count   = shadow_q[TF_COUNT - TF_FEAT];
    assign tf_lba0    = shadow_q[TF_LBA0  - TF_FEAT];
    assign tf_lba1    = shadow_q[TF_LBA1  - TF_FEAT];
    assign tf_lba2    = shadow_q[TF_LBA2  - TF_FEAT];
    assign tf_device  = shadow_q[TF_DEV   - TF_FEAT];

    AST_STROBE_EXCL: assert property (@(posedge clk) disable iff (!rst_n) $onehot0({cmd_valid, ctl_valid, pio_wr, pio_rd})); // R10
    AST_STROBE_ACK: assert property (@(posedge clk) disable iff (!rst_n) (cmd_valid || ctl_valid || pio_wr || pio_rd) |-> bus_ack); // R10
    AST_COUNT_GATED: assert property (@(posedge clk) disable iff (!rst_n) !$stable(tf_count) |-> $past(!dev_status[BSY_BIT] && !dev_status[DRQ_BIT])); // R3
    AST_FEAT_GATED: assert property (@(posedge clk) disable iff (!rst_n) !$stable(tf_feature) |-> $past(!dev_status[BSY_BIT] && !dev_status[DRQ_BIT])); // R3
    AST_CMD_CLEARS: assert property (@(posedge clk) disable iff (!rst_n) (cmd_valid && !dev_done) |=> !irq); // R6
    AST_IDLE_RDATA: assert property (@(posedge clk) disable iff (!rst_n) !bus_ack |-> (bus_rdata == '0)); // R2
endmodule

// File: tb/sim_tf_frontend.sv
module sim_tf_frontend;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_sel = 1'b0;
    logic        bus_wr = 1'b0;
    logic [3:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic        bus_ack;
    logic [31:0] bus_rdata;
    logic [7:0]  dev_status = 8'h50;
    logic [7:0]  dev_error = 8'h04;
    logic        dev_done = 1'b0;
    logic [15:0] dev_pio_rdata = 16'hBEEF;
    logic        cmd_valid, ctl_valid, pio_wr, pio_rd, irq;
    logic [7:0]  cmd_code, ctl_data;
    logic [15:0] pio_wdata;
    logic [7:0]  tf_feature, tf_count, tf_lba0, tf_lba1, tf_lba2, tf_device;

    tf_frontend u0 (
        .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_ack(bus_ack),
        .bus_rdata(bus_rdata), .dev_status(dev_status), .dev_error(dev_error),
        .dev_done(dev_done), .dev_pio_rdata(dev_pio_rdata),
        .cmd_valid(cmd_valid), .cmd_code(cmd_code), .ctl_valid(ctl_valid),
        .ctl_data(ctl_data), .pio_wr(pio_wr), .pio_rd(pio_rd),
        .pio_wdata(pio_wdata), .tf_feature(tf_feature), .tf_count(tf_count),
        .tf_lba0(tf_lba0), .tf_lba1(tf_lba1), .tf_lba2(tf_lba2),
        .tf_device(tf_device), .irq(irq)
    );

    always #10 clk = ~clk;

    int n_chk = 0;
    int n_err = 0;
    int cyc = 0;
    bit ended = 0;

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Behavioural reference model, advanced on every rising edge
    bit          m_busy = 0;
    bit          m_irq = 0;
    bit          p_wr = 0;
    int          p_addr = 0;
    logic [31:0] p_wd = '0;
    logic [7:0]  m_sh [16];
    logic [31:0] m_scr [16];

    function automatic bit gate_open();
        return (dev_status[7] == 1'b0) && (dev_status[3] == 1'b0);
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            m_busy = 0;
            m_irq = 0;
            for (int k = 0; k < 16; k++) begin
                m_sh[k] = '0;
                m_scr[k] = '0;
            end
        end else begin
            if (m_busy) begin
                if (p_wr) begin
                    if (p_addr >= 1 && p_addr <= 6 && gate_open()) m_sh[p_addr] = p_wd[7:0];
                    if (p_addr == 7 && gate_open()) m_irq = 0;
                    if (p_addr >= 9) m_scr[p_addr] = p_wd;
                end else if (p_addr == 7) begin
                    m_irq = 0;
                end
                m_busy = 0;
            end else if (bus_sel) begin
                p_wr = bus_wr;
                p_addr = int'(bus_addr);
                p_wd = bus_wdata;
                m_busy = 1;
            end
            if (dev_done) m_irq = 1;
        end
        #5;
        begin
            logic [3:0]  exp_str;
            logic [31:0] exp_rd;
            string       rtag;
            exp_str = {m_busy && p_wr && p_addr == 7 && gate_open(),
                       m_busy && p_wr && p_addr == 8,
                       m_busy && p_wr && p_addr == 0,
                       m_busy && !p_wr && p_addr == 0};
            exp_rd = '0;
            rtag = "R12 rdata";
            if (m_busy && !p_wr) begin
                if (p_addr == 0) begin exp_rd = {16'h0, dev_pio_rdata}; rtag = "R9 rdata"; end
                else if (p_addr == 1) begin exp_rd = {24'h0, dev_error}; rtag = "R5 rdata"; end
                else if (p_addr <= 6) begin exp_rd = {24'h0, m_sh[p_addr]}; rtag = "R3 rdata"; end
                else if (p_addr <= 8) begin exp_rd = {24'h0, dev_status}; rtag = "R7 rdata"; end
                else exp_rd = m_scr[p_addr];
            end
            chk("R2 ack", 64'(bus_ack), 64'(m_busy));
            chk("R10 strobes", 64'({cmd_valid, ctl_valid, pio_wr, pio_rd}), 64'(exp_str));
            chk(rtag, 64'(bus_rdata), 64'(exp_rd));
            chk("R11 irq", 64'(irq), 64'(m_irq));
            chk("R3 shadows", {16'h0, tf_feature, tf_count, tf_lba0, tf_lba1, tf_lba2, tf_device},
                {16'h0, m_sh[1], m_sh[2], m_sh[3], m_sh[4], m_sh[5], m_sh[6]});
            if (exp_str[3]) chk("R6 cmd_code", 64'(cmd_code), 64'(p_wd[7:0]));
        end
    end

    logic [31:0] rd;
    logic [3:0]  stb;
    logic [7:0]  last_cmd, last_ctl;
    logic [15:0] last_pio;

    task automatic access(input bit wr, input int addr, input logic [31:0] wd, input bit done_in);
        @(negedge clk);
        bus_sel = 1'b1;
        bus_wr = wr;
        bus_addr = addr[3:0];
        bus_wdata = wd;
        @(negedge clk);
        rd = bus_rdata;
        stb = {cmd_valid, ctl_valid, pio_wr, pio_rd};
        last_cmd = cmd_code;
        last_ctl = ctl_data;
        last_pio = pio_wdata;
        bus_sel = 1'b0;
        dev_done = done_in;
        @(negedge clk);
        dev_done = 1'b0;
    endtask

    task automatic pulse_done();
        @(negedge clk);
        dev_done = 1'b1;
        @(negedge clk);
        dev_done = 1'b0;
    endtask

    task automatic finish_run();
        if (!ended) begin
            ended = 1;
            $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
            $finish;
        end
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 20000) begin
            n_chk++;
            n_err++;
            $display("FAIL watchdog actual=%0d expected=<20000", cyc);
            finish_run();
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 reset outputs", {tf_feature, tf_count, tf_lba0, tf_lba1, tf_lba2, tf_device, 6'b0, irq, bus_ack},
            64'h0);

        access(1, 1, 32'hDEADBEA5, 0);
        chk("R4 low byte", 64'(tf_feature), 64'hA5);
        access(0, 1, 32'h0, 0);
        chk("R5 error on read", 64'(rd), 64'h04);

        access(1, 2, 32'h11, 0);
        access(1, 3, 32'h22, 0);
        access(1, 4, 32'h33, 0);
        access(1, 5, 32'h44, 0);
        access(1, 6, 32'hE0, 0);
        chk("R3 accepted", {tf_count, tf_lba0, tf_lba1, tf_lba2, tf_device}, 40'h11223344E0);
        access(0, 2, 32'h0, 0);
        chk("R3 readback", 64'(rd), 64'h11);

        dev_status = 8'h80;
        access(1, 2, 32'h77, 0);
        chk("R3 busy drop", 64'(tf_count), 64'h11);
        dev_status = 8'h08;
        access(1, 4, 32'h99, 0);
        chk("R3 drq drop", 64'(tf_lba1), 64'h33);

        pulse_done();
        access(1, 7, 32'hEC, 0);
        chk("R6 refused cmd", 64'({stb, 3'b0, irq}), 64'({4'b0000, 3'b0, 1'b1}));

        access(0, 8, 32'h0, 0);
        chk("R8 alt read", 64'({rd[7:0], 7'b0, irq}), 64'({8'h08, 7'b0, 1'b1}));
        access(1, 8, 32'h106, 0);
        chk("R8 ctl strobe", 64'({stb, last_ctl}), 64'({4'b0100, 8'h06}));

        access(0, 7, 32'h0, 0);
        chk("R7 status read", 64'({rd[7:0], 7'b0, irq}), 64'({8'h08, 8'h00}));

        dev_status = 8'h50;
        pulse_done();
        chk("R11 set", 64'(irq), 64'h1);
        access(1, 7, 32'h1EC, 0);
        chk("R6 cmd accepted", 64'({stb, last_cmd, 7'b0, irq}), 64'({4'b1000, 8'hEC, 8'h00}));

        pulse_done();
        access(0, 7, 32'h0, 1);
        chk("R11 set wins", 64'(irq), 64'h1);

        dev_status = 8'h88;
        access(1, 0, 32'hABCD1234, 0);
        chk("R9 data write", 64'({stb, last_pio}), 64'({4'b0010, 16'h1234}));
        access(0, 0, 32'h0, 0);
        chk("R9 data read", 64'({stb, rd}), 64'({4'b0001, 32'h0000BEEF}));

        access(1, 9, 32'hCAFEF00D, 0);
        access(1, 15, 32'h01234567, 0);
        access(0, 9, 32'h0, 0);
        chk("R12 scratch lo", 64'(rd), 64'hCAFEF00D);
        access(0, 15, 32'h0, 0);
        chk("R12 scratch hi", 64'(rd), 64'h01234567);
        access(0, 10, 32'h0, 0);
        chk("R12 scratch unwritten", 64'(rd), 64'h0);

        @(negedge clk);
        bus_sel = 1'b1;
        bus_wr = 1'b0;
        bus_addr = 4'd8;
        @(negedge clk);
        chk("R2 held select ack", 64'(bus_ack), 64'h1);
        @(negedge clk);
        chk("R2 held select gap", 64'(bus_ack), 64'h0);
        @(negedge clk);
        chk("R2 held select again", 64'(bus_ack), 64'h1);
        bus_sel = 1'b0;
        repeat (3) @(negedge clk);
        chk("R10 quiet", 64'({cmd_valid, ctl_valid, pio_wr, pio_rd}), 64'h0);

        finish_run();
    end
endmodule